// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the host-facing front end of a bank of 8-bit configuration registers. The host sees a two-byte I/O window. Offset 0 is an index port and offset 1 is a data port. The register bank stays hidden until the host writes a fixed unlock key byte to the index port twice in a row. The key gives no acknowledgement. While the bank is open, an index-port write picks a register and a data-port access reads or writes that register. A single lock byte written to the index port closes the bank again.

The block holds a few global registers itself: a read-only identity byte, a read-only revision byte, a read-only strap byte, and a logical-device selector. Every register address at or above a forwarding base belongs to the logical device that the selector currently picks. For those addresses the block drives the selector value, the register address, the write data and a write strobe to the downstream devices, and it returns their read data to the host. Address decoding above the two ports is done elsewhere. The block only reports, on `win_base`, which window base its strap parameter selects.

The host bus is a one-cycle request strobe with a write flag, a one-bit offset and a data byte. Read data is registered: it appears one cycle after the request and stays until the next read.

Top module: `keyed_cfg_port`

## Requirements
- R1: After a synchronous active-low reset the port is locked, `host_rdata` is 0xFF, `host_rvalid` is 0, the index is 0x00 and `dev_sel` is 0x00.
- R2: Two index-port writes of 0x87 with no other index-port write between them open the bank. An index-port write of any other value while locked discards the partial key. Data-port accesses between the two key writes do not disturb the key.
- R3: While locked, a data-port write changes no register, and a read of either port returns 0xFF.
- R4: While open, an index-port write of 0xAA locks the port. From the next request on, reads return 0xFF.
- R5: A read request loads `host_rdata` at the clock edge where the request is taken, and `host_rvalid` is 1 for exactly the following cycle. `host_rdata` holds its value until the next read request.
- R6: While open, a read of offset 0 returns the current index. An index-port write of any value other than 0xAA, including 0x87, sets the index.
- R7: Register 0x20 reads the ID_BYTE parameter and register 0x21 reads the REV_BYTE parameter. Data writes to either register are ignored.
- R8: Register 0x26 reads bit 6 equal to the STRAP_HI parameter, with all other bits 0. `win_base` is 0x002E when STRAP_HI is 0 and 0x004E when it is 1.
- R9: Register 0x07 is a read/write logical-device selector. Its value drives `dev_sel`.
- R10: For an index of 0x30 or above, a data write while open raises `dev_we` for one cycle with `dev_addr` equal to the index and `dev_wdata` equal to the written byte. A data read returns `dev_rdata` for the device that `dev_sel` selects.
- R11: Other indices below 0x30 (not 0x07, 0x20, 0x21 or 0x26) read 0x00, and writes to them are ignored.
- R12: Locking clears the index to 0x00, so after the next unlock offset 0 reads 0x00. The device selector keeps its value across lock and unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | Window offset: 0 index port, 1 data port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| host_rvalid | output | 1 | High the cycle after a read request |
| cfg_mode | output | 1 | Bank is open |
| win_base | output | 16 | Window base selected by the strap |
| dev_sel | output | 8 | Selected logical device |
| dev_addr | output | 8 | Device register address (current index) |
| dev_wdata | output | 8 | Device write byte |
| dev_we | output | 1 | Device write strobe |
| dev_rdata | input | 8 | Read byte from the selected device, combinational on dev_sel/dev_addr |

## Verification
The assertions assume that the host raises `host_req` for single cycles, with the request fields held steady across the sampling edge. They also assume that `dev_rdata` is a pure combinational function of `dev_sel` and `dev_addr`. The bench drives every request from a task at the falling edge and holds it through one rising edge. Its downstream stub answers from a small register array indexed by the low nibbles of selector and address, so device traffic stays within selectors 0–15 and registers 0x30–0x3F.

// File: rtl/cfgp_pkg.sv
// Shared types and register addresses of the keyed configuration port.
// Assumes byte-wide registers throughout.
package cfgp_pkg;
    localparam int DW = 8;
    typedef logic [DW-1:0] cbyte_t;

    typedef enum logic [1:0] {
        KEY_SHUT = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    localparam cbyte_t REG_LDN   = 8'h07;
    localparam cbyte_t REG_ID    = 8'h20;
    localparam cbyte_t REG_REV   = 8'h21;
    localparam cbyte_t REG_STRAP = 8'h26;
    localparam cbyte_t FWD_BASE  = 8'h30;
    localparam int     STRAP_BIT = 6;
    localparam cbyte_t LOCKED_RD = 8'hFF;
endpackage

// File: rtl/cfgp_key_fsm.sv
// Unlock key tracker. Watches index-port writes and opens the bank after two
// consecutive KEY_ON bytes; KEY_OFF closes it. Assumes idx_wr is a one-cycle
// strobe qualified by the host request.
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter cbyte_t KEY_ON  = 8'h87,
    parameter cbyte_t KEY_OFF = 8'hAA
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   idx_wr,
    input  cbyte_t wdata,
    output logic   open
);
    key_state_e st;

    // Key progress: advances on KEY_ON, falls back on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KEY_SHUT;
        end else if (idx_wr) begin
            case (st)
                KEY_SHUT: st <= (wdata == KEY_ON) ? KEY_HALF : KEY_SHUT;
                KEY_HALF: st <= (wdata == KEY_ON) ? KEY_OPEN : KEY_SHUT;
                KEY_OPEN: st <= (wdata == KEY_OFF) ? KEY_SHUT : KEY_OPEN;
                default:  st <= KEY_SHUT;
            endcase
        end
    end

    // Open flag for the rest of the port.
    always_comb open = (st == KEY_OPEN);

    // R2: the bank opens only from the half-key state on a key write
    a_r2_open_from_half: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !$past(open)) |-> ($past(st) == KEY_HALF && $past(idx_wr) && $past(wdata) == KEY_ON));

    // R4: the lock byte closes an open bank
    a_r4_off_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == KEY_OFF) |=> !open);
endmodule

// File: rtl/cfgp_global_bank.sv
// Global register bank: the logical-device selector plus read-only identity,
// revision and strap bytes. Assumes writes are already qualified by the open
// state and the data-port offset.
module cfgp_global_bank
    import cfgp_pkg::*;
#(
    parameter cbyte_t ID_BYTE  = 8'hA5,
    parameter cbyte_t REV_BYTE = 8'h3C,
    parameter bit     STRAP_HI = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   data_wr,
    input  cbyte_t idx,
    input  cbyte_t wdata,
    output cbyte_t ldn,
    output cbyte_t glb_rdata
);
    localparam cbyte_t STRAP_BYTE = cbyte_t'(STRAP_HI) << STRAP_BIT;

    // Logical-device selector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn <= '0;
        end else if (data_wr && idx == REG_LDN) begin
            ldn <= wdata;
        end
    end

    // Read mux over the global registers; unknown addresses read zero.
    always_comb begin
        case (idx)
            REG_LDN:   glb_rdata = ldn;
            REG_ID:    glb_rdata = ID_BYTE;
            REG_REV:   glb_rdata = REV_BYTE;
            REG_STRAP: glb_rdata = STRAP_BYTE;
            default:   glb_rdata = '0;
        endcase
    end

    // R9: the selector changes only on a data write addressed to it
    a_r9_ldn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && idx == REG_LDN) |=> $stable(ldn));
endmodule

// File: rtl/cfgp_dev_fwd.sv
// Forwarding path to the logical devices: any index at or above FWD_BASE is
// passed down with a write strobe, and the device's byte is returned.
// Assumes dev_rdata is combinational on the outgoing selector and address.
module cfgp_dev_fwd
    import cfgp_pkg::*;
(
    input  logic   data_wr,
    input  cbyte_t idx,
    input  cbyte_t wdata,
    input  cbyte_t dev_rdata,
    output logic   fwd_hit,
    output cbyte_t fwd_rdata,
    output cbyte_t dev_addr,
    output cbyte_t dev_wdata,
    output logic   dev_we
);
    // Decode the device window and drive the device bus.
    always_comb begin
        fwd_hit   = (idx >= FWD_BASE);
        dev_addr  = idx;
        dev_wdata = wdata;
        dev_we    = data_wr && fwd_hit;
        fwd_rdata = dev_rdata;
    end
endmodule

// File: rtl/keyed_cfg_port.sv
// Keyed index/data configuration port. Owns the index register and the
// registered read path; delegates key tracking, global registers and device
// forwarding. Assumes host_req is a one-cycle strobe with stable fields.
module keyed_cfg_port
    import cfgp_pkg::*;
#(
    parameter cbyte_t      KEY_ON       = 8'h87,
    parameter cbyte_t      KEY_OFF      = 8'hAA,
    parameter cbyte_t      ID_BYTE      = 8'hA5,
    parameter cbyte_t      REV_BYTE     = 8'h3C,
    parameter bit          STRAP_HI     = 1'b0,
    parameter logic [15:0] PORT_LO_BASE = 16'h002E,
    parameter logic [15:0] PORT_HI_BASE = 16'h004E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic          host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          cfg_mode,
    output logic [15:0]   win_base,
    output logic [DW-1:0] dev_sel,
    output logic [DW-1:0] dev_addr,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_we,
    input  logic [DW-1:0] dev_rdata
);
    logic   idx_wr, data_wr, rd_req, open, fwd_hit;
    cbyte_t idx, glb_rdata, fwd_rdata, rd_val;

    // Qualified host strobes.
    always_comb begin
        idx_wr  = host_req && host_we && !host_addr;
        data_wr = host_req && host_we && host_addr && open;
        rd_req  = host_req && !host_we;
    end

    cfgp_key_fsm #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_key (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(host_wdata), .open(open)
    );

    cfgp_global_bank #(.ID_BYTE(ID_BYTE), .REV_BYTE(REV_BYTE), .STRAP_HI(STRAP_HI)) u_glb (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx), .wdata(host_wdata),
        .ldn(dev_sel), .glb_rdata(glb_rdata)
    );

    cfgp_dev_fwd u_fwd (
        .data_wr(data_wr), .idx(idx), .wdata(host_wdata), .dev_rdata(dev_rdata),
        .fwd_hit(fwd_hit), .fwd_rdata(fwd_rdata), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_we(dev_we)
    );

    // Index register: cleared while locked, loaded by non-lock index writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!open) begin
            idx <= '0;
        end else if (idx_wr && host_wdata != KEY_OFF) begin
            idx <= host_wdata;
        end
    end

    // Read value selection for both ports.
    always_comb begin
        if (!open)          rd_val = LOCKED_RD;
        else if (!host_addr) rd_val = idx;
        else if (fwd_hit)   rd_val = fwd_rdata;
        else                rd_val = glb_rdata;
    end

    // Registered read data and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= LOCKED_RD;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_req;
            if (rd_req) host_rdata <= rd_val;
        end
    end

    // Strap-selected window base.
    generate
        if (STRAP_HI) begin : g_base_hi
            assign win_base = PORT_HI_BASE;
        end else begin : g_base_lo
            assign win_base = PORT_LO_BASE;
        end
    endgenerate

    // Open flag to the outside.
    always_comb cfg_mode = open;

    // R3: a read while locked returns the locked byte next cycle
    a_r3_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && !cfg_mode) |=> (host_rdata == LOCKED_RD && host_rvalid));

    // R5: without a read request the read data holds and valid is low
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> ($stable(host_rdata) && !host_rvalid));

    // R10: a device write strobe only appears while open and inside the window
    a_r10_fwd_window: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> (cfg_mode && dev_addr >= FWD_BASE && host_addr));
endmodule

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb;
    localparam int     CLK_PERIOD = 10;
    localparam int     WATCHDOG   = 5000;
    localparam [7:0]   P_ID  = 8'hA5;
    localparam [7:0]   P_REV = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hreq = 1'b0, hwe = 1'b0, haddr = 1'b0;
    logic [7:0] hwdata = 8'h00;
    logic [7:0] rdata, dsel, daddr, dwdata, drdata;
    logic rvalid, cmode, dwe;
    logic [15:0] wbase;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(hreq), .host_we(hwe), .host_addr(haddr),
        .host_wdata(hwdata), .host_rdata(rdata), .host_rvalid(rvalid), .cfg_mode(cmode),
        .win_base(wbase), .dev_sel(dsel), .dev_addr(daddr), .dev_wdata(dwdata),
        .dev_we(dwe), .dev_rdata(drdata)
    );

    // Downstream device stub: 16 devices x 16 registers.
    logic [7:0] stub [0:255];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) stub[i] <= 8'h00;
        end else if (dwe) begin
            stub[{dsel[3:0], daddr[3:0]}] <= dwdata;
        end
    end
    assign drdata = stub[{dsel[3:0], daddr[3:0]}];

    // Behavioural reference model.
    int m_state = 0;          // 0 shut, 1 half key, 2 open
    int m_idx = 0;
    int m_ldn = 0;
    int m_rd = 8'hFF;
    int m_rv = 0;
    int m_dev [int];

    function automatic int reg_value(int a);
        if (a == 8'h07) return m_ldn;
        if (a == 8'h20) return P_ID;
        if (a == 8'h21) return P_REV;
        if (a == 8'h26) return 0;          // strap low: bit 6 clear
        if (a >= 8'h30) begin
            int k = (m_ldn % 16) * 16 + (a % 16);
            return m_dev.exists(k) ? m_dev[k] : 0;
        end
        return 0;
    endfunction

    task automatic model_step(input bit rq, input bit we, input bit a, input int d);
        int rv = 8'hFF;
        int old = m_state;
        if (old == 2) rv = a ? reg_value(m_idx) : m_idx;
        if (rq && !we) m_rd = rv;
        m_rv = (rq && !we) ? 1 : 0;
        if (rq && we && a && old == 2) begin
            if (m_idx == 8'h07) m_ldn = d;
            if (m_idx >= 8'h30) m_dev[(m_ldn % 16) * 16 + (m_idx % 16)] = d;
        end
        if (old != 2) m_idx = 0;
        else if (rq && we && !a && d != 8'hAA) m_idx = d;
        if (rq && we && !a) begin
            if (old == 0) m_state = (d == 8'h87) ? 1 : 0;
            else if (old == 1) m_state = (d == 8'h87) ? 2 : 0;
            else m_state = (d == 8'hAA) ? 0 : 2;
        end
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (rdata !== 8'(m_rd) || rvalid !== 1'(m_rv) ||
            cmode !== (m_state == 2) || dsel !== 8'(m_ldn)) begin
            n_fail++;
            $display("FAIL %s: rdata=%h rvalid=%b mode=%b sel=%h expected rdata=%h rvalid=%0d mode=%0d sel=%h",
                     tag, rdata, rvalid, cmode, dsel, m_rd[7:0], m_rv, (m_state == 2), m_ldn[7:0]);
        end
    endtask

    // One host cycle: compare at the falling edge, drive, take the rising edge.
    task automatic cyc(input bit rq, input bit we, input bit a, input logic [7:0] d, input string tag);
        @(negedge clk);
        compare(tag);
        hreq = rq; hwe = we; haddr = a; hwdata = d;
        @(posedge clk);
        model_step(rq, we, a, int'(d));
    endtask

    task automatic idx_wr(input logic [7:0] d, input string tag);  cyc(1, 1, 0, d, tag); endtask
    task automatic dat_wr(input logic [7:0] d, input string tag);  cyc(1, 1, 1, d, tag); endtask
    task automatic rd(input bit a, input string tag);               cyc(1, 0, a, 8'h00, tag); endtask
    task automatic idle(input string tag);                          cyc(0, 0, 0, 8'h00, tag); endtask
    task automatic unlock(input string tag);
        idx_wr(8'h87, tag); idx_wr(8'h87, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1"); idle("R1");
        n_checks++;
        if (wbase !== 16'h002E) begin
            n_fail++;
            $display("FAIL R8: win_base=%h expected 002e", wbase);
        end
        // R3: locked port
        rd(1, "R3"); rd(0, "R3"); dat_wr(8'h55, "R3"); rd(1, "R3");
        // R2: interrupted key, then key with data access in between
        idx_wr(8'h87, "R2"); idx_wr(8'h55, "R2"); idx_wr(8'h87, "R2");
        rd(1, "R2"); idx_wr(8'h87, "R2"); idle("R2");
        // R6: index read back
        idx_wr(8'h20, "R6"); rd(0, "R6");
        // R7: identity and revision are read-only
        rd(1, "R7"); dat_wr(8'h00, "R7"); rd(1, "R7");
        idx_wr(8'h21, "R7"); rd(1, "R7"); dat_wr(8'h11, "R7"); rd(1, "R7");
        // R8: strap byte
        idx_wr(8'h26, "R8"); rd(1, "R8"); dat_wr(8'hFF, "R8"); rd(1, "R8");
        // R11: unused low address
        idx_wr(8'h10, "R11"); dat_wr(8'h77, "R11"); rd(1, "R11");
        // R9: device selector
        idx_wr(8'h07, "R9"); dat_wr(8'h03, "R9"); rd(1, "R9");
        // R10: forwarded device registers
        idx_wr(8'h31, "R10"); dat_wr(8'h5A, "R10"); rd(1, "R10");
        idx_wr(8'h07, "R10"); dat_wr(8'h05, "R10");
        idx_wr(8'h31, "R10"); rd(1, "R10"); dat_wr(8'hC3, "R10"); rd(1, "R10");
        idx_wr(8'h07, "R10"); dat_wr(8'h03, "R10");
        idx_wr(8'h31, "R10"); rd(1, "R10");
        idx_wr(8'h3F, "R10"); dat_wr(8'h81, "R10"); rd(1, "R10");
        // R5: read data held, valid only one cycle
        idle("R5"); idle("R5"); dat_wr(8'h12, "R5"); idle("R5"); rd(1, "R5"); idle("R5");
        // R6: key byte while open just sets the index
        idx_wr(8'h87, "R6"); rd(0, "R6"); idx_wr(8'h87, "R6"); rd(0, "R6");
        // R4: lock byte, then locked accesses
        idx_wr(8'h07, "R4"); idx_wr(8'hAA, "R4"); rd(1, "R4"); rd(0, "R4");
        dat_wr(8'h09, "R3"); idle("R3");
        // R12: index cleared, selector kept
        unlock("R12"); rd(0, "R12");
        idx_wr(8'h07, "R12"); rd(1, "R12");
        idx_wr(8'h31, "R12"); rd(1, "R12");
        idle("R12"); idle("R12");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule